// File: doc/BRIEF.md
# Key-Guarded Peripheral Reset Pulser

This block lets software reset individual peripherals through a small register window. Five 32-bit reset banks map one bit to each peripheral, in the same bit arrangement the chip uses for its clock-gating banks. A one written to a bank bit launches a reset pulse of fixed length on the matching output; zeros do nothing. Nothing is stored, so every bank reads back as zero.

A guard register protects the banks. A specific 32-bit key opens the guard. A second key, one count higher, closes it. Any other value leaves the guard as it was. While the guard is closed, writes to the banks are dropped. The guard comes out of reset closed. Reading the guard register returns one bit that shows whether it is open.

The guard is a two-state machine. State `LK_LOCKED` is entered at reset. Transition *open* goes from `LK_LOCKED` to `LK_OPEN` on the open key. Transition *close* goes from `LK_OPEN` to `LK_LOCKED` on the close key. Every other write holds the current state. Each output bit has its own down-counter. A triggered write loads the counter, and the output stays high while the counter is non-zero.

Top module: `prst_lockbank`

## Requirements
- R1: After reset the guard is closed, every reset output is low, and reading the guard register (word index 5) returns 0.
- R2: Writing 0xA6382D4C to the guard register (word index 5) opens the guard, and bit 0 of its readback becomes 1 on the next cycle.
- R3: Writing 0xA6382D4D to the guard register closes the guard, and its readback bit 0 becomes 0.
- R4: Writing any other value to the guard register leaves the guard state unchanged, whether it is open or closed.
- R5: While the guard is closed, writes to the reset banks (word indices 0 to 4) raise no reset output.
- R6: While the guard is open, a write to bank k raises output k*32+b for every bit b written as one. The output goes high in the cycle after the write and stays high for exactly 8 clock cycles. Bits written as zero leave their outputs untouched.
- R7: Reading any reset bank returns 0, including while pulses are running.
- R8: Writing a one again to a bit whose pulse is still running restarts its full 8-cycle length from that write.
- R9: Closing the guard while pulses are running does not shorten them.
- R10: Writes to the unused word indices 6 and 7 change nothing, even when they carry a key value, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Word index: 0 to 4 are the reset banks, 5 is the guard |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr (combinational) |
| periph_rst | output | 160 | Reset pulses, bank k bit b at index k*32+b |

## Verification
Two functions can act in the same cycle. One is the guard's close transition. The other is the countdown of a pulse that was launched just before it. The bench opens the guard, triggers a bank bit, and closes the guard on the very next bus cycle. It then counts the remaining high cycles of that output and expects exactly the length left from the original trigger, with the guard readback at 0. A second overlap rewrites a bit in the middle of its pulse. The bench expects a fresh full-length pulse measured from the second write.

// File: rtl/prst_pkg.sv
package prst_pkg;

    localparam logic [31:0] OPEN_KEY  = 32'hA638_2D4C;
    localparam logic [31:0] CLOSE_KEY = 32'hA638_2D4D;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_e;

endpackage

// File: rtl/prst_lock_fsm.sv
module prst_lock_fsm
    import prst_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_val,
    output logic        is_open
);

    lock_state_e state_q;
    lock_state_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: begin
                if (key_wr && (key_val == OPEN_KEY)) begin
                    state_d = LK_OPEN;
                end
            end
            LK_OPEN: begin
                if (key_wr && (key_val == CLOSE_KEY)) begin
                    state_d = LK_LOCKED;
                end
            end
            default: state_d = LK_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        is_open = (state_q == LK_OPEN);
    end

endmodule

// File: rtl/prst_wr_decode.sv
module prst_wr_decode #(
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 3,
    localparam int TOTAL_W  = NUM_BANKS * BANK_W,
    localparam int GUARD_IX = NUM_BANKS
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    input  logic              is_open,
    output logic              key_wr,
    output logic [TOTAL_W-1:0] trig
);

    assign key_wr = bus_wr && (bus_addr == ADDR_W'(GUARD_IX));

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        logic sel;
        assign sel = bus_wr && is_open && (bus_addr == ADDR_W'(k));
        assign trig[k*BANK_W +: BANK_W] = sel ? bus_wdata : '0;
    end

endmodule

// File: rtl/prst_pulse_bank.sv
module prst_pulse_bank #(
    parameter int WIDTH     = 160,
    parameter int PULSE_LEN = 8,
    localparam int CNT_W    = $clog2(PULSE_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] trig,
    output logic [WIDTH-1:0] pulse
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (trig[i]) begin
                cnt_q <= CNT_W'(PULSE_LEN);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end

        assign pulse[i] = (cnt_q != '0);
    end

endmodule

// File: rtl/prst_lockbank.sv
module prst_lockbank #(
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 32,
    parameter int PULSE_LEN = 8,
    parameter int ADDR_W    = 3,
    localparam int TOTAL_W  = NUM_BANKS * BANK_W,
    localparam int GUARD_IX = NUM_BANKS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BANK_W-1:0]  bus_wdata,
    output logic [BANK_W-1:0]  bus_rdata,
    output logic [TOTAL_W-1:0] periph_rst
);

    logic               lock_open;
    logic               key_wr;
    logic [TOTAL_W-1:0] trig;

    prst_lock_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .key_val (bus_wdata),
        .is_open (lock_open)
    );

    prst_wr_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .is_open   (lock_open),
        .key_wr    (key_wr),
        .trig      (trig)
    );

    prst_pulse_bank #(
        .WIDTH     (TOTAL_W),
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig),
        .pulse (periph_rst)
    );

    // banks are write-only; only the guard word returns state
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(GUARD_IX)) begin
            bus_rdata[0] = lock_open;
        end
    end

endmodule

// File: rtl/prst_lockbank_chk.sv
module prst_lockbank_chk #(
    parameter int NUM_BANKS = 5,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 3,
    localparam int TOTAL_W  = NUM_BANKS * BANK_W,
    localparam int GUARD_IX = NUM_BANKS
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [BANK_W-1:0]  bus_wdata,
    input logic [BANK_W-1:0]  bus_rdata,
    input logic [TOTAL_W-1:0] periph_rst,
    input logic               lock_open
);

    logic               guard_wr;
    logic [TOTAL_W-1:0] wmask;

    assign guard_wr = bus_wr && (bus_addr == ADDR_W'(GUARD_IX));

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_m
        assign wmask[k*BANK_W +: BANK_W] =
            (bus_wr && lock_open && (bus_addr == ADDR_W'(k))) ? bus_wdata : '0;
    end

    // R2
    open_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_wr && bus_wdata == prst_pkg::OPEN_KEY && !lock_open) |=> lock_open);

    // R3
    close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_wr && bus_wdata == prst_pkg::CLOSE_KEY) |=> !lock_open);

    // R4
    other_val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard_wr || (bus_wdata != prst_pkg::OPEN_KEY && bus_wdata != prst_pkg::CLOSE_KEY))
        |=> $stable(lock_open));

    // R5
    no_unarmed_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((periph_rst & ~$past(periph_rst) & ~$past(wmask)) == '0));

    // R6
    armed_write_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wmask != '0) |=> ((periph_rst & $past(wmask)) == $past(wmask)));

    // R7
    bank_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != ADDR_W'(GUARD_IX)) |-> (bus_rdata == '0));

endmodule

bind prst_lockbank prst_lockbank_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .periph_rst (periph_rst),
    .lock_open  (lock_open)
);

// File: tb/prst_lockbank_tb_top.sv
`timescale 1ns/1ps
module prst_lockbank_tb_top;

    localparam int TOTAL = 160;
    localparam logic [31:0] KOPEN  = 32'hA638_2D4C;
    localparam logic [31:0] KCLOSE = 32'hA638_2D4D;
    localparam int NVEC = 11;
    // {addr[2:0], data[31:0], expected guard readback}
    localparam logic [35:0] VEC [NVEC] = '{
        {3'd5, 32'h1234_5678, 1'b0},
        {3'd5, KCLOSE,        1'b0},
        {3'd5, KOPEN,         1'b1},
        {3'd5, 32'h0000_0000, 1'b1},
        {3'd5, KOPEN,         1'b1},
        {3'd5, 32'hA638_2D4E, 1'b1},
        {3'd5, KCLOSE,        1'b0},
        {3'd6, KOPEN,         1'b0},
        {3'd5, KOPEN,         1'b1},
        {3'd7, KCLOSE,        1'b1},
        {3'd5, KCLOSE,        1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [2:0]       bus_addr = 3'd0;
    logic [31:0]      bus_wdata = 32'd0;
    logic [31:0]      bus_rdata;
    logic [TOTAL-1:0] periph_rst;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    prst_lockbank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .periph_rst (periph_rst)
    );

    task automatic check(input bit ok, input string req, input logic [159:0] act,
                         input logic [159:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the capturing edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_wdata = 32'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic count_high(input int idx, output int n);
        n = 0;
        while (periph_rst[idx] && n < 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int n;
        bit quiet;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd5, r);
        check(r == 32'd0, "R1 guard readback", 160'(r), 160'd0);
        check(periph_rst == '0, "R1 outputs low", periph_rst, 160'd0);

        // table walk: R2 R3 R4 R10 guard transitions
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][35:33], VEC[i][32:1]);
            rd(3'd5, r);
            check(r == {31'd0, VEC[i][0]}, $sformatf("R2/R3/R4/R10 vec %0d", i),
                  160'(r), 160'(VEC[i][0]));
        end

        // R5 closed guard drops bank writes
        wr(3'd2, 32'hFFFF_FFFF);
        quiet = 1'b1;
        for (int c = 0; c < 10; c++) begin
            if (periph_rst != '0) quiet = 1'b0;
            @(negedge clk);
        end
        check(quiet, "R5 no pulse while locked", periph_rst, 160'd0);

        // R10 unused addresses read zero
        rd(3'd6, r);
        check(r == 32'd0, "R10 read idx6", 160'(r), 160'd0);

        wr(3'd5, KOPEN);

        // R6 single bit pulse length
        wr(3'd0, 32'h0000_0001);
        check(periph_rst == 160'd1, "R6 only bit0", periph_rst, 160'd1);
        count_high(0, n);
        check(n == 8, "R6 bit0 length", 160'(n), 160'd8);

        wr(3'd4, 32'h8000_0000);
        count_high(159, n);
        check(n == 8, "R6 bank4 bit31 length", 160'(n), 160'd8);

        wr(3'd3, 32'h0000_0005);
        check(periph_rst == ((160'd1 << 96) | (160'd1 << 98)), "R6 zero bits untouched",
              periph_rst, (160'd1 << 96) | (160'd1 << 98));
        // R7 bank read while running
        rd(3'd3, r);
        check(r == 32'd0, "R7 bank3 read", 160'(r), 160'd0);
        rd(3'd0, r);
        check(r == 32'd0, "R7 bank0 read", 160'(r), 160'd0);
        repeat (10) @(negedge clk);

        // R8 retrigger mid pulse
        wr(3'd1, 32'h0000_0008);
        repeat (4) @(negedge clk);
        wr(3'd1, 32'h0000_0008);
        count_high(35, n);
        check(n == 8, "R8 retrigger length", 160'(n), 160'd8);

        // R9 close guard right after a trigger
        wr(3'd2, 32'h0000_0080);
        wr(3'd5, KCLOSE);
        rd(3'd5, r);
        check(r == 32'd0, "R9 guard closed", 160'(r), 160'd0);
        count_high(71, n);
        check(n == 7, "R9 pulse not cut", 160'(n), 160'd7);
        wr(3'd2, 32'h0000_0080);
        check(periph_rst == '0, "R5 closed after R9", periph_rst, 160'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule